// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block guesses, at instruction fetch, whether a conditional branch will be taken and where it goes. A direct-mapped table, indexed by the fetch address, keeps one record per branch. Each record holds an address tag, the last resolved target, a two-bit saturating confidence counter and a short shift register of recent outcomes. When the fetch address matches a valid record, the counter picks the direction and the stored target is offered. When nothing matches, a fixed rule takes over: a branch that jumps backward (negative displacement, as reported by the decoder) is guessed taken, and a forward one is guessed not taken.

Resolved branches come back through an update port with their address, outcome and real target. A resolved branch that already has a record moves its counter one step and shifts its history. A resolved branch with no record claims the slot, and any earlier occupant is lost. Lookup is pipelined by one register stage, so the guess for the address presented in one cycle appears after the next rising edge. This suits a synchronous block RAM.

Top module: `bp_predictor`

## Requirements
- R1: After synchronous reset every record is invalid: lookups report `pred_hit`=0 until an update writes the slot, and right after reset `pred_taken`, `pred_target` and `pred_history` are 0.
- R2: The outputs after a rising edge describe the `fetch_pc` and `fetch_disp_neg` sampled at that edge (one-cycle lookup latency).
- R3: The slot index is `pc[OFFSET_W+IDX_W-1:OFFSET_W]` and the tag is `pc[PC_W-1:OFFSET_W+IDX_W]`. The low `OFFSET_W` bits are ignored. A hit needs a valid slot whose tag equals the fetch tag.
- R4: On a miss, `pred_hit`=0, `pred_taken` equals `fetch_disp_neg`, and `pred_target` and `pred_history` are 0.
- R5: On a hit, `pred_target` is the stored target and `pred_taken` is bit 1 of the counter. The counter encoding is 0 strong not-taken, 1 weak not-taken, 2 weak taken and 3 strong taken.
- R6: An update that hits moves the counter up by one when taken and down by one when not taken. It stays at 3 and at 0.
- R7: An update that misses allocates the slot. It writes the tag and target, sets the counter to 2 if taken or 1 if not, and sets the history to the outcome in bit 0 with the other bits 0.
- R8: An update that hits shifts the history left by one and places the new outcome in bit 0. The oldest bit is dropped.
- R9: An update that hits replaces the stored target with `upd_target`.
- R10: When a lookup and an update address the same slot in the same cycle, the lookup reports the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_disp_neg | input | 1 | Decoded displacement is negative (for the miss rule) |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | PC_W | Resolved target |
| pred_hit | output | 1 | Lookup matched a valid record |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | PC_W | Predicted target, 0 on a miss |
| pred_history | output | HIST_W | Outcome history of the matched record, 0 on a miss |

## Verification
The hardest condition to create is a lookup and an update that address the same slot in the same edge. The slot must already hold a record, so that both the old and the new contents are visible and differ. The stimulus first fills every slot with known targets and outcomes. It then runs a directed step where fetch and update carry the same address, followed by a long pseudo-random phase that draws both addresses from a tiny tag range, so these collisions, tag evictions and counter saturation recur many times.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_e;

  function automatic ctr_e ctr_saturate(input ctr_e cur, input logic taken);
    ctr_e r;
    if (taken) r = (cur == CTR_ST) ? CTR_ST : ctr_e'(cur + 2'd1);
    else       r = (cur == CTR_SNT) ? CTR_SNT : ctr_e'(cur - 2'd1);
    return r;
  endfunction
endpackage

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
  import bp_pkg::*;
(
  input  ctr_e cur,
  input  logic taken,
  input  logic alloc,
  output ctr_e nxt
);
  always_comb begin
    if (alloc) nxt = taken ? CTR_WT : CTR_WNT;
    else       nxt = ctr_saturate(cur, taken);
  end
endmodule

// File: rtl/bp_hist_shift.sv
module bp_hist_shift #(
  parameter int HIST_W = 4
) (
  input  logic [HIST_W-1:0] cur,
  input  logic              outcome,
  input  logic              clear,
  output logic [HIST_W-1:0] nxt
);
  assign nxt[0] = outcome;
  for (genvar i = 1; i < HIST_W; i++) begin : g_bit
    assign nxt[i] = clear ? 1'b0 : cur[i-1];
  end
endmodule

// File: rtl/bp_btb_table.sv
module bp_btb_table #(
  parameter int ENTRIES = 512,
  parameter int TAG_W   = 21,
  parameter int TGT_W   = 32,
  parameter int HIST_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  // lookup side: registered read, read-first on collision
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [TGT_W-1:0]  rd_tgt,
  output logic [1:0]        rd_ctr,
  output logic [HIST_W-1:0] rd_hist,
  // update side: asynchronous read of the slot being trained
  input  logic [IDX_W-1:0]  up_idx,
  output logic              up_valid,
  output logic [TAG_W-1:0]  up_tag,
  output logic [1:0]        up_ctr,
  output logic [HIST_W-1:0] up_hist,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [TGT_W-1:0]  wr_tgt,
  input  logic [1:0]        wr_ctr,
  input  logic [HIST_W-1:0] wr_hist
);
  logic [TAG_W-1:0]  tag_mem  [ENTRIES];
  logic [TGT_W-1:0]  tgt_mem  [ENTRIES];
  logic [1:0]        ctr_mem  [ENTRIES];
  logic [HIST_W-1:0] hist_mem [ENTRIES];
  logic [ENTRIES-1:0] valid_vec;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[up_idx]  <= wr_tag;
      tgt_mem[up_idx]  <= wr_tgt;
      ctr_mem[up_idx]  <= wr_ctr;
      hist_mem[up_idx] <= wr_hist;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        valid_vec <= '0;
    else if (wr_en) valid_vec[up_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    rd_tag  <= tag_mem[rd_idx];
    rd_tgt  <= tgt_mem[rd_idx];
    rd_ctr  <= ctr_mem[rd_idx];
    rd_hist <= hist_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= valid_vec[rd_idx];
  end

  assign up_valid = valid_vec[up_idx];
  assign up_tag   = tag_mem[up_idx];
  assign up_ctr   = ctr_mem[up_idx];
  assign up_hist  = hist_mem[up_idx];
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ENTRIES  = 512,
  parameter int OFFSET_W = 2,
  parameter int HIST_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic              fetch_disp_neg,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [PC_W-1:0]   upd_target,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [PC_W-1:0]   pred_target,
  output logic [HIST_W-1:0] pred_history
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - OFFSET_W;
  localparam int TAG_LO = OFFSET_W + IDX_W;

  logic [IDX_W-1:0]  f_idx, u_idx;
  logic [TAG_W-1:0]  f_tag, u_tag;
  logic [TAG_W-1:0]  f_tag_q;
  logic              neg_q;

  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [PC_W-1:0]   rd_tgt;
  logic [1:0]        rd_ctr;
  logic [HIST_W-1:0] rd_hist;

  logic              s_valid;
  logic [TAG_W-1:0]  s_tag;
  logic [1:0]        s_ctr;
  logic [HIST_W-1:0] s_hist;

  logic              u_hit;
  ctr_e              ctr_nxt;
  logic [HIST_W-1:0] hist_nxt;
  logic [1:0]        wr_ctr;

  assign f_idx = fetch_pc[TAG_LO-1:OFFSET_W];
  assign f_tag = fetch_pc[PC_W-1:TAG_LO];
  assign u_idx = upd_pc[TAG_LO-1:OFFSET_W];
  assign u_tag = upd_pc[PC_W-1:TAG_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      f_tag_q <= '0;
      neg_q   <= 1'b0;
    end else begin
      f_tag_q <= f_tag;
      neg_q   <= fetch_disp_neg;
    end
  end

  bp_btb_table #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .TGT_W(PC_W), .HIST_W(HIST_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .rd_idx(f_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
    .rd_ctr(rd_ctr), .rd_hist(rd_hist),
    .up_idx(u_idx), .up_valid(s_valid), .up_tag(s_tag), .up_ctr(s_ctr),
    .up_hist(s_hist),
    .wr_en(upd_valid), .wr_tag(u_tag), .wr_tgt(upd_target), .wr_ctr(wr_ctr),
    .wr_hist(hist_nxt)
  );

  assign u_hit = s_valid && (s_tag == u_tag);

  bp_ctr_next u_ctr (
    .cur(ctr_e'(s_ctr)), .taken(upd_taken), .alloc(!u_hit), .nxt(ctr_nxt)
  );
  assign wr_ctr = ctr_nxt;

  bp_hist_shift #(.HIST_W(HIST_W)) u_hist (
    .cur(s_hist), .outcome(upd_taken), .clear(!u_hit), .nxt(hist_nxt)
  );

  logic look_hit;
  assign look_hit     = rd_valid && (rd_tag == f_tag_q);
  assign pred_hit     = look_hit;
  assign pred_taken   = look_hit ? rd_ctr[1] : neg_q;
  assign pred_target  = look_hit ? rd_tgt : '0;
  assign pred_history = look_hit ? rd_hist : '0;

  // R1: the first lookup after reset cannot hit
  a_r1_reset_miss: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_hit);

  // R6: a trained counter moves by exactly one step toward the outcome, or holds at the end
  a_r6_saturate_step: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && u_hit) |->
      (upd_taken ? ((wr_ctr == s_ctr + 2'd1) || (s_ctr == 2'd3 && wr_ctr == 2'd3))
                 : ((wr_ctr == s_ctr - 2'd1) || (s_ctr == 2'd0 && wr_ctr == 2'd0))));

  // R7: a newly allocated record starts in a weak state matching the outcome
  a_r7_alloc_weak: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !u_hit) |-> (wr_ctr == (upd_taken ? 2'd2 : 2'd1)));

  // R8: the newest outcome lands in history bit 0, older bits move up
  a_r8_hist_shift: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && u_hit) |-> (hist_nxt[0] == upd_taken) &&
      (hist_nxt[HIST_W-1:1] == s_hist[HIST_W-2:0]));

  // R4: a miss never reports a target
  a_r4_miss_no_target: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (pred_target == '0 && pred_history == '0));
endmodule

// File: tb/bp_predictor_test.sv
`timescale 1ns/1ps
module bp_predictor_test;
  localparam int PC_W = 12;
  localparam int ENTRIES = 8;
  localparam int OFFSET_W = 2;
  localparam int HIST_W = 4;

  logic clk = 1'b0;
  logic rst;
  logic [PC_W-1:0] fetch_pc, upd_pc, upd_target;
  logic fetch_disp_neg, upd_valid, upd_taken;
  logic pred_hit, pred_taken;
  logic [PC_W-1:0] pred_target;
  logic [HIST_W-1:0] pred_history;

  int errors = 0;
  int checks = 0;

  bit         m_valid [ENTRIES];
  logic [6:0] m_tag   [ENTRIES];
  logic [PC_W-1:0] m_tgt [ENTRIES];
  int         m_ctr   [ENTRIES];
  logic [HIST_W-1:0] m_hist [ENTRIES];

  always #2.5 clk = ~clk;

  bp_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES), .OFFSET_W(OFFSET_W), .HIST_W(HIST_W)) uut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_disp_neg(fetch_disp_neg),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .pred_history(pred_history)
  );

  task automatic clear_model();
    for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
  endtask

  task automatic compare(input string req, input logic eh, input logic et,
                         input logic [PC_W-1:0] eg, input logic [HIST_W-1:0] ey);
    checks++;
    if (pred_hit !== eh || pred_taken !== et || pred_target !== eg || pred_history !== ey) begin
      errors++;
      $display("FAIL %s: hit/taken/target/hist actual %b/%b/%h/%b expected %b/%b/%h/%b",
               req, pred_hit, pred_taken, pred_target, pred_history, eh, et, eg, ey);
    end
  endtask

  // one lookup plus optional update; outputs checked one edge later
  task automatic step(input logic [PC_W-1:0] fpc, input logic fneg, input logic uv,
                      input logic [PC_W-1:0] upc, input logic ut,
                      input logic [PC_W-1:0] utgt, input string req);
    int fi, ui;
    logic eh, et;
    logic [PC_W-1:0] eg;
    logic [HIST_W-1:0] ey;
    @(negedge clk);
    fetch_pc = fpc; fetch_disp_neg = fneg;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
    fi = int'(fpc[4:2]);
    eh = m_valid[fi] && (m_tag[fi] == fpc[11:5]);
    et = eh ? (m_ctr[fi] >= 2) : fneg;
    eg = eh ? m_tgt[fi] : '0;
    ey = eh ? m_hist[fi] : '0;
    if (uv) begin
      ui = int'(upc[4:2]);
      if (m_valid[ui] && m_tag[ui] == upc[11:5]) begin
        m_ctr[ui] = ut ? ((m_ctr[ui] == 3) ? 3 : m_ctr[ui] + 1)
                       : ((m_ctr[ui] == 0) ? 0 : m_ctr[ui] - 1);
        m_hist[ui] = {m_hist[ui][HIST_W-2:0], ut};
      end else begin
        m_valid[ui] = 1;
        m_tag[ui] = upc[11:5];
        m_ctr[ui] = ut ? 2 : 1;
        m_hist[ui] = {{(HIST_W-1){1'b0}}, ut};
      end
      m_tgt[ui] = utgt;
    end
    @(posedge clk);
    #1;
    compare(req, eh, et, eg, ey);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [PC_W-1:0] a;
    rst = 1'b1; fetch_pc = '0; fetch_disp_neg = 0; upd_valid = 0;
    upd_pc = '0; upd_taken = 0; upd_target = '0;
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    step('0, 1'b0, 1'b0, '0, 1'b0, '0, "R1");
    // R4: static fallback for every slot, both signs
    for (int i = 0; i < ENTRIES; i++)
      for (int n = 0; n < 2; n++)
        step(PC_W'(i << 2), n[0], 1'b0, '0, 1'b0, '0, "R4");
    // R7: allocate every slot with tag 3
    for (int i = 0; i < ENTRIES; i++)
      step('0, 1'b0, 1'b1, PC_W'((3 << 5) | (i << 2)), i[0], PC_W'(12'h100 + i), "R7");
    // R3/R5: lookups hit, with stray offset bits
    for (int i = 0; i < ENTRIES; i++)
      step(PC_W'((3 << 5) | (i << 2) | (i & 3)), 1'b1, 1'b0, '0, 1'b0, '0, "R3");
    // R3: same index other tag misses
    step(PC_W'((4 << 5) | (5 << 2)), 1'b1, 1'b0, '0, 1'b0, '0, "R3");
    // R6/R8/R9: train slot 5, look after each update
    for (int k = 0; k < 14; k++) begin
      logic o;
      o = (k < 4) || (k >= 10 && k != 12);
      step('0, 1'b0, 1'b1, PC_W'((3 << 5) | (5 << 2)), o, PC_W'(12'h200 + k), "R9");
      step(PC_W'((3 << 5) | (5 << 2)), 1'b0, 1'b0, '0, 1'b0, '0, "R6");
    end
    // R10: lookup and update on the same slot together, then after
    step(PC_W'((3 << 5) | (2 << 2)), 1'b0, 1'b1, PC_W'((3 << 5) | (2 << 2)), 1'b1, 12'h3AA, "R10");
    step(PC_W'((3 << 5) | (2 << 2)), 1'b0, 1'b0, '0, 1'b0, '0, "R10");
    step(PC_W'((6 << 5) | (2 << 2)), 1'b1, 1'b1, PC_W'((6 << 5) | (2 << 2)), 1'b0, 12'h3BB, "R10");
    step(PC_W'((6 << 5) | (2 << 2)), 1'b1, 1'b0, '0, 1'b0, '0, "R8");
    // R2: pseudo-random sweep over a small tag range
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {5'b0, lfsr[1:0], lfsr[4:2], lfsr[6:5]};
      step({5'b0, lfsr[8:7], lfsr[11:9], 2'b00}, lfsr[12], lfsr[13], a, lfsr[14],
           {lfsr[15:8], lfsr[3:0]}, "R2");
    end
    // R1: reset again wipes records
    @(negedge clk); rst = 1'b1; upd_valid = 0;
    @(negedge clk); rst = 1'b0;
    clear_model();
    step(PC_W'((3 << 5) | (5 << 2)), 1'b0, 1'b0, '0, 1'b0, '0, "R1");
    step(PC_W'((3 << 5) | (1 << 2)), 1'b1, 1'b0, '0, 1'b0, '0, "R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule